// File: doc/BRIEF.md
# IDCT Pixel Reconstruction Stage

This block finishes one column of an inverse DCT. It takes eight signed column-pass sums that have not yet been scaled. It turns each sum into an 8-bit pixel and writes the eight pixels down one column of a byte-addressed frame memory. The distance between rows is a byte stride that is supplied at run time.

The block has two modes. In put mode, each pixel is the scaled sum clipped to 0..255. In add mode, the block first reads the prediction byte already stored at each location, adds the scaled sum to it, clips the result and writes it back.

Columns of an 8x8 block are normally processed left to right. A chain request therefore starts the new column one byte to the right of the previous column's base, so the caller does not have to supply that address again.

Top module: `pixel_recon`

## Requirements
- R1: In put mode (`add_mode`=0), pixel k written to memory equals the k-th result arithmetically shifted right by `SHIFT` (default 20, rounding toward minus infinity), then clamped.
- R2: In add mode (`add_mode`=1), pixel k equals the byte read from its address plus the shifted result, clamped. With a stride of 0, each add uses the value written by the previous pixel.
- R3: Clamping maps any negative value to 0 and any value above 255 to 255. Values in between pass through unchanged.
- R4: Pixel k (k = 0..7, result k in bits [32k+31:32k] of `results`) is written to address base + k*stride, modulo 2^ADDR_W, in ascending k order. Every write moves the address on by the stride.
- R5: A start with `chain`=1 ignores `base` and uses the previous column's base plus one.
- R6: In put mode, pixel k is written in cycle k+1 after the start edge. `done` is high for exactly one cycle, in cycle 9 for put mode and cycle 17 for add mode, with `busy` already low.
- R7: In add mode, each write is preceded in the previous cycle by a read of the same address. `mem_rd` and `mem_wr` are never high together.
- R8: `start` is ignored while `busy` is high. It causes no extra memory access and leaves the chained base unchanged.
- R9: After reset the block is idle, with `busy`, `done`, `mem_rd` and `mem_wr` low, and the chained base is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one column, sampled while idle |
| add_mode | input | 1 | 1 = add to stored prediction, 0 = put |
| chain | input | 1 | 1 = base is previous base + 1 |
| base | input | ADDR_W | Byte address of pixel 0 |
| stride | input | STRIDE_W | Line stride in bytes |
| results | input | NPIX*RES_W | Unscaled column sums, result k at bits [RES_W*k +: RES_W] |
| mem_addr | output | ADDR_W | Frame memory address |
| mem_rd | output | 1 | Read strobe, data valid one cycle later |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Pixel to write |
| mem_rdata | input | 8 | Read data from frame memory |
| busy | output | 1 | Column in progress |
| done | output | 1 | One-cycle pulse after the eighth write |

## Verification
The bench builds the block with ADDR_W and STRIDE_W set to 10. This lets it model the whole 1 KiB frame memory and compare every byte after each column. It also lets a modest stride wrap the address past the top of memory. The default SHIFT of 20 and 32-bit results let the bench test floor rounding of negative sums, clipping at both ends, accumulation with a zero stride, and chained bases starting from the reset value.

// File: rtl/pixel_recon.sv
module pixel_recon #(
  parameter int ADDR_W   = 16,
  parameter int STRIDE_W = 16,
  parameter int RES_W    = 32,
  parameter int SHIFT    = 20,
  parameter int NPIX     = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    add_mode,
  input  logic                    chain,
  input  logic [ADDR_W-1:0]       base,
  input  logic [STRIDE_W-1:0]     stride,
  input  logic [NPIX*RES_W-1:0]   results,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic                    mem_rd,
  output logic                    mem_wr,
  output logic [7:0]              mem_wdata,
  input  logic [7:0]              mem_rdata,
  output logic                    busy,
  output logic                    done
);
  localparam int IDX_W = (NPIX > 1) ? $clog2(NPIX) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NPIX - 1);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t                    st;
  logic [IDX_W-1:0]       idx;
  logic [ADDR_W-1:0]      addr_q;
  logic [ADDR_W-1:0]      col_base;
  logic [STRIDE_W-1:0]    stride_q;
  logic                   mode_q;
  logic [NPIX*RES_W-1:0]  res_q;
  logic                   done_q;

  logic [ADDR_W-1:0]      start_base;
  logic [ADDR_W-1:0]      stride_ext;
  logic signed [RES_W-1:0] cur;
  logic signed [RES_W-1:0] scaled;
  logic signed [RES_W:0]   sum;
  logic [7:0]             pix;

  assign start_base = chain ? col_base + 1'b1 : base;
  assign stride_ext = ADDR_W'(stride_q);

  assign cur    = res_q[idx*RES_W +: RES_W];
  assign scaled = cur >>> SHIFT;
  assign sum    = {scaled[RES_W-1], scaled} +
                  (mode_q ? {{(RES_W-7){1'b0}}, mem_rdata} : '0);

  always_comb begin
    if (sum < 0)        pix = 8'd0;
    else if (sum > 255) pix = 8'd255;
    else                pix = sum[7:0];
  end

  assign mem_addr  = addr_q;
  assign mem_rd    = (st == S_RD);
  assign mem_wr    = (st == S_WR);
  assign mem_wdata = pix;
  assign busy      = (st != S_IDLE);
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      addr_q   <= '0;
      col_base <= '0;
      stride_q <= '0;
      mode_q   <= 1'b0;
      res_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          mode_q   <= add_mode;
          stride_q <= stride;
          res_q    <= results;
          col_base <= start_base;
          addr_q   <= start_base;
          idx      <= '0;
          st       <= add_mode ? S_RD : S_WR;
        end
        S_RD: st <= S_WR;
        S_WR: begin
          addr_q <= addr_q + stride_ext;
          if (idx == LAST) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
            st  <= mode_q ? S_RD : S_WR;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module pixel_recon_chk #(
  parameter int ADDR_W   = 16,
  parameter int STRIDE_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic                mem_rd,
  input logic                mem_wr,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic [STRIDE_W-1:0] stride_q
);
  assert_rd_wr_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_read_then_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (mem_wr && mem_addr == $past(mem_addr)));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (mem_addr == $past(mem_addr) + ADDR_W'($past(stride_q))));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_wr && !mem_rd));

  assert_start_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr));
endmodule

bind pixel_recon pixel_recon_chk #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .stride_q(stride_q)
);

// File: tb/pixel_recon_test.sv
`timescale 1ns/1ps
module pixel_recon_test;
  localparam int AW = 10;
  localparam int SW = 10;
  localparam int RW = 32;
  localparam int NP = 8;
  localparam int MEMSZ = 1 << AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, add_mode = 1'b0, chain = 1'b0;
  logic [AW-1:0] base = '0;
  logic [SW-1:0] stride = '0;
  logic [NP*RW-1:0] results = '0;
  logic [AW-1:0] mem_addr;
  logic mem_rd, mem_wr, busy, done;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = '0;

  pixel_recon #(.ADDR_W(AW), .STRIDE_W(SW), .RES_W(RW), .SHIFT(20), .NPIX(NP)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .add_mode(add_mode), .chain(chain),
    .base(base), .stride(stride), .results(results), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done));

  logic [7:0] mem [MEMSZ];
  logic [7:0] ref_mem [MEMSZ];
  int checks = 0, failures = 0;
  int exp_a[$], exp_d[$];
  int prev_base = 0;
  int res_v[NP];
  string tag = "R1";

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd && mem_wr) begin
        checks++; failures++;
        $display("FAIL R7 read and write together actual=1 expected=0");
      end
      if (mem_wr) begin
        checks++;
        if (exp_a.size() == 0) begin
          failures++;
          $display("FAIL R8 unexpected write addr=%0d data=%0d expected no write", mem_addr, mem_wdata);
        end else begin
          int a, d;
          a = exp_a.pop_front();
          d = exp_d.pop_front();
          if (int'(mem_addr) != a || int'(mem_wdata) != d) begin
            failures++;
            $display("FAIL %s/R4 write actual addr=%0d data=%0d expected addr=%0d data=%0d",
                     tag, mem_addr, mem_wdata, a, d);
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare_mem(input string req);
    int bad = 0;
    for (int i = 0; i < MEMSZ; i++) if (mem[i] !== ref_mem[i]) bad++;
    check(bad == 0, req, bad, 0);
  endtask

  task automatic run_col(input bit am, input bit ch, input int b, input int st,
                         input bit poke, input string t);
    int bb, a, v, ncyc;
    logic [NP*RW-1:0] pk;
    tag = t;
    bb = ch ? (prev_base + 1) % MEMSZ : b;
    prev_base = bb;
    for (int k = 0; k < NP; k++) begin
      a = (bb + k * st) % MEMSZ;
      v = res_v[k] >>> 20;
      if (am) v = v + int'(ref_mem[a]);
      if (v < 0) v = 0;
      if (v > 255) v = 255;
      ref_mem[a] = 8'(v);
      exp_a.push_back(a);
      exp_d.push_back(v);
      pk[k*RW +: RW] = res_v[k];
    end
    @(posedge clk); #1;
    start = 1'b1; add_mode = am; chain = ch; base = AW'(b); stride = SW'(st); results = pk;
    @(posedge clk); #1;
    start = 1'b0;
    ncyc = am ? 17 : 9;
    for (int n = 1; n <= ncyc; n++) begin
      @(negedge clk);
      if (n < ncyc) check(busy && !done, "R6 busy during column", int'(done), 0);
      else check(done && !busy, "R6 done timing", int'(done), 1);
      if (poke && n == 3) begin start = 1'b1; chain = 1'b0; base = AW'(500); end
      if (poke && n == 4) start = 1'b0;
    end
    @(negedge clk);
    check(!done, "R6 done one cycle", int'(done), 0);
    check(exp_a.size() == 0, {t, " all writes issued"}, exp_a.size(), 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      check(!busy, "R8 start while busy ignored", int'(busy), 0);
    end
    compare_mem({t, " memory image"});
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEMSZ; i++) begin
      mem[i] = 8'((i * 37) & 255);
      ref_mem[i] = 8'((i * 37) & 255);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy && !done && !mem_rd && !mem_wr, "R9 reset idle", int'(busy), 0);
    #1 rst_n = 1'b1;

    // R9 / R5: chain right after reset starts at 0 + 1
    for (int k = 0; k < NP; k++) res_v[k] = (k * 20) << 20;
    run_col(1'b0, 1'b1, 777, 16, 1'b0, "R5");

    // R1 / R3: put, rounding and clipping
    res_v[0] = (17 << 20) + 5;
    res_v[1] = 255 << 20;
    res_v[2] = 256 << 20;
    res_v[3] = -1;
    res_v[4] = 2000 << 20;
    res_v[5] = -(1000 << 20);
    res_v[6] = (128 << 20) + (1 << 20) - 1;
    res_v[7] = (3 << 20) - 1;
    run_col(1'b0, 1'b0, 100, 16, 1'b0, "R1/R3");

    // R2 / R3: add with both clip directions
    res_v[0] = 10 << 20;
    res_v[1] = -(300 << 20);
    res_v[2] = 300 << 20;
    res_v[3] = -(1 << 20);
    res_v[4] = 0;
    res_v[5] = (50 << 20) + 123;
    res_v[6] = -((5 << 20) + 1);
    res_v[7] = 255 << 20;
    run_col(1'b1, 1'b0, 200, 32, 1'b0, "R2/R3");

    // R5: chained add starts at previous base + 1
    run_col(1'b1, 1'b1, 3, 32, 1'b0, "R5/R2");

    // R2: stride zero accumulates in place
    for (int k = 0; k < NP; k++) res_v[k] = 40 << 20;
    run_col(1'b1, 1'b0, 5, 0, 1'b0, "R2 stride0");

    // R4: address wraps modulo memory size
    for (int k = 0; k < NP; k++) res_v[k] = (k * 30 + 7) << 20;
    run_col(1'b0, 1'b0, 1000, 100, 1'b0, "R4 wrap");

    // R8: start pulsed mid-column is ignored
    for (int k = 0; k < NP; k++) res_v[k] = (200 - k) << 20;
    run_col(1'b0, 1'b0, 300, 8, 1'b1, "R8");

    // R8: chained base not disturbed by ignored start
    run_col(1'b0, 1'b1, 0, 8, 1'b0, "R8/R5");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule